// File: doc/BRIEF.md
# Phase-Offset Sine Synthesis Core

This block is the digital core of a direct digital synthesizer. On every clock it adds a frequency increment to a wide phase register. A coarse phase offset is then added to the most significant bits of that phase. The top bits of the result select a sample from a sine table, and the sample goes out as an unsigned amplitude word for an external DAC. The output frequency is the increment times the clock rate divided by two to the accumulator width. The increment is therefore proportional to the tone frequency that results.

The offset word shifts the output in binary fractions of a turn. With five offset bits these are 180, 90, 45, 22.5 and 11.25 degrees, and any mix of them may be set. The offset acts only on the table address and never on the stored phase. A power-down input freezes the phase, parks the output at mid-scale and drops the valid flag. Loading of control words, sweep sequencing and the analog stages around the block belong to other logic.

Top module: `dds_phase_core`

## Requirements
- R1: At the first clock edge with `rst` high, the phase register is cleared to 0, `ampOut` becomes 512 and `ampValid` becomes 0.
- R2: On each clock edge with `rst` and `powerDown` both low, the phase register increases by `freqWord`, modulo 2^32.
- R3: The table address is taken from phase bits [31:20]. Changes confined to bits [19:0] never alter `ampOut`.
- R4: `phaseWord` is added, modulo 32, to address bits [11:7]. Bit 4 shifts by 180 degrees, bit 3 by 90, bit 2 by 45, bit 1 by 22.5 and bit 0 by 11.25. Any combination of bits may be set, and the offset never enters the stored phase.
- R5: For a table address a, let s = sin(2*pi*(a+0.5)/4096). The sample is 512+round(511*s) when s >= 0, and 511-round(511*|s|) otherwise. Thus address 0 gives 512, address 1024 gives 1023 and address 2048 gives 511.
- R6: The phase value held after edge k, together with the `phaseWord` present at edge k+1, sets `ampOut` after edge k+2.
- R7: At each edge where `powerDown` is high and `rst` is low, the phase register keeps its value, `ampOut` becomes 512 and `ampValid` becomes 0.
- R8: After reset or power-down is released, `ampValid` goes high at the second clock edge and stays high while the block runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freqWord | input | 32 | Phase increment added on each running clock |
| phaseWord | input | 5 | Coarse phase offset in steps of 1/32 turn |
| powerDown | input | 1 | Freezes the phase and parks the output at mid-scale |
| ampOut | output | 10 | Unsigned sine amplitude, mid-scale 512 |
| ampValid | output | 1 | High when `ampOut` comes from the running pipeline |

## Verification
The bench builds the core with its default values: a 32-bit accumulator, a 12-bit table address, a 10-bit amplitude and a 5-bit offset. With these widths an increment of 2^20 moves the address by exactly one entry per clock, so one sweep of 4096 cycles reaches every table address in all four quadrants. An increment of one shows that the truncated low bits have no effect. An increment just below 2^32 drives the phase backwards across the wrap point. Each offset bit is applied alone and in combination, with the phase both fixed and moving. The bench also toggles power-down and reset during a run.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef struct packed {
    logic clear;  // synchronous reset of all state
    logic step;   // advance phase and pipeline
    logic park;   // hold phase, force mid-scale output
  } dds_strobe_t;
endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        powerDown,
  output dds_strobe_t strobe,
  output logic        validOut
);
  logic stage1Live;

  always_comb begin
    strobe.clear = rst;
    strobe.step  = !rst && !powerDown;
    strobe.park  = !rst && powerDown;
  end

  always_ff @(posedge clk) begin
    if (!strobe.step) begin
      stage1Live <= 1'b0;
      validOut   <= 1'b0;
    end else begin
      stage1Live <= 1'b1;
      validOut   <= stage1Live;
    end
  end

  // R8: valid only after two consecutive running edges
  p_valid_two_steps_r8: assert property (@(posedge clk) disable iff (rst)
    validOut |-> ($past(strobe.step) && $past(strobe.step, 2)));

  // R7: a parked edge always drops valid
  p_park_drops_valid_r7: assert property (@(posedge clk) disable iff (rst)
    powerDown |=> !validOut);
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [AMP_W-1:0]  sample
);
  localparam int QTR_W   = ADDR_W - 2;
  localparam int QTR_N   = 2 ** QTR_W;
  localparam int MAG_W   = AMP_W - 1;
  localparam int FULL_N  = 2 ** ADDR_W;
  localparam int MAG_MAX = 2 ** MAG_W - 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(2 ** MAG_W);

  function automatic logic [MAG_W-1:0] magOf(input int k);
    real ang;
    ang = 3.14159265358979 * (2.0 * k + 1.0) / real'(FULL_N);
    magOf = MAG_W'($rtoi(real'(MAG_MAX) * $sin(ang) + 0.5));
  endfunction

  logic [MAG_W-1:0] quarterTab [QTR_N];

  for (genvar i = 0; i < QTR_N; i++) begin : g_tab
    assign quarterTab[i] = magOf(i);
  end

  logic [QTR_W-1:0] foldIdx;
  logic [MAG_W-1:0] mag;

  always_comb begin
    foldIdx = addr[ADDR_W-2] ? ~addr[QTR_W-1:0] : addr[QTR_W-1:0];
    mag     = quarterTab[foldIdx];
    if (addr[ADDR_W-1])
      sample = (MID - AMP_W'(1)) - AMP_W'(mag);
    else
      sample = MID + AMP_W'(mag);
  end
endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 10,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  dds_strobe_t       strobe,
  input  logic [ACC_W-1:0]  freqWord,
  input  logic [OFF_W-1:0]  phaseWord,
  output logic [AMP_W-1:0]  ampOut
);
  localparam int PAD_W = ADDR_W - OFF_W;
  localparam logic [AMP_W-1:0] MID = AMP_W'(2 ** (AMP_W - 1));

  logic [ACC_W-1:0]  phaseAcc;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrNext;
  logic [AMP_W-1:0]  romSample;

  assign addrNext = phaseAcc[ACC_W-1 -: ADDR_W] + {phaseWord, {PAD_W{1'b0}}};

  dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .addr   (addrQ),
    .sample (romSample)
  );

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      phaseAcc <= '0;
      addrQ    <= '0;
      ampOut   <= MID;
    end else if (strobe.step) begin
      phaseAcc <= phaseAcc + freqWord;
      addrQ    <= addrNext;
      ampOut   <= romSample;
    end else begin
      ampOut   <= MID;
    end
  end

  // R2: running edge advances the phase by the increment
  p_acc_step_r2: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.step |=> phaseAcc == $past(phaseAcc) + $past(freqWord));

  // R7: parked edge keeps the phase
  p_acc_hold_r7: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.park |=> $stable(phaseAcc));

  // R7: parked edge forces mid-scale
  p_park_mid_r7: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.park |=> ampOut == MID);

  // R1: reset leaves mid-scale and zero phase
  p_reset_state_r1: assert property (@(posedge clk)
    strobe.clear |=> (ampOut == MID && phaseAcc == '0));
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 10,
  parameter int OFF_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freqWord,
  input  logic [OFF_W-1:0] phaseWord,
  input  logic             powerDown,
  output logic [AMP_W-1:0] ampOut,
  output logic             ampValid
);
  dds_strobe_t strobe;

  dds_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .powerDown (powerDown),
    .strobe    (strobe),
    .validOut  (ampValid)
  );

  dds_datapath #(
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .OFF_W(OFF_W)
  ) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .freqWord  (freqWord),
    .phaseWord (phaseWord),
    .ampOut    (ampOut)
  );
endmodule

// File: tb/dds_phase_core_test.sv
module dds_phase_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freqWord = '0;
  logic [4:0]  phaseWord = '0;
  logic        powerDown = 1'b0;
  logic [9:0]  ampOut;
  logic        ampValid;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";

  // reference state
  longint unsigned mAcc = 0;
  int mAddr = 0;
  int mAmp = 512;
  bit mLive = 0;
  bit mValid = 0;
  int addrQueue[$];

  dds_phase_core uut (
    .clk(clk), .rst(rst), .freqWord(freqWord), .phaseWord(phaseWord),
    .powerDown(powerDown), .ampOut(ampOut), .ampValid(ampValid)
  );

  always #4 clk = ~clk;

  function automatic int sineAt(input int a);
    real s;
    s = $sin(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 4096.0);
    if (s >= 0.0) return 512 + $rtoi(511.0 * s + 0.5);
    return 511 - $rtoi(-511.0 * s + 0.5);
  endfunction

  task automatic modelEdge();
    if (rst) begin
      mAcc = 0; mAddr = 0; mAmp = 512; mLive = 0; mValid = 0;
    end else if (powerDown) begin
      mAmp = 512; mLive = 0; mValid = 0;
    end else begin
      mAmp = sineAt(mAddr);
      mAddr = (int'(mAcc >> 20) + int'(phaseWord) * 128) % 4096;
      mAcc = (mAcc + longint'(freqWord)) & 64'hFFFF_FFFF;
      mValid = mLive;
      mLive = 1;
    end
  endtask

  task automatic compare(input string req);
    vectors++;
    if (int'(ampOut) != mAmp || ampValid != mValid) begin
      miscompares++;
      $display("FAIL %s: ampOut=%0d ampValid=%0b expected %0d/%0b at %0t",
               req, ampOut, ampValid, mAmp, mValid, $time);
    end
  endtask

  task automatic cycle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelEdge();
      @(negedge clk);
      compare(curReq);
    end
  endtask

  task automatic expectAmp(input int want, input string req);
    vectors++;
    if (int'(ampOut) != want) begin
      miscompares++;
      $display("FAIL %s: ampOut=%0d expected %0d", req, ampOut, want);
    end
  endtask

  initial begin
    #1_600_000;
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    curReq = "R1"; rst = 1'b1; cycle(3);
    expectAmp(512, "R1");
    rst = 1'b0;

    // R8 / R6: valid rises on the second running edge; address 0 first
    curReq = "R8"; freqWord = 32'd0; cycle(3);
    curReq = "R5"; expectAmp(512, "R5");

    // R4: 90 degree and 180 degree offsets at fixed phase
    curReq = "R4"; phaseWord = 5'd8; cycle(3); expectAmp(1023, "R4");
    phaseWord = 5'd16; cycle(3); expectAmp(511, "R4");
    for (int b = 0; b < 5; b++) begin
      phaseWord = 5'(1 << b); cycle(3);
    end
    phaseWord = 5'd31; cycle(3);
    phaseWord = 5'd21; cycle(3);

    // R3: increments inside truncated bits do not move output
    curReq = "R3"; phaseWord = 5'd0; freqWord = 32'd1; cycle(200);

    // R5 / R6: one table entry per clock, full sweep
    curReq = "R5"; freqWord = 32'h0010_0000; cycle(4200);

    // R4: offsets while phase runs, changing each few cycles
    curReq = "R4"; freqWord = 32'h0123_4567;
    for (int p = 0; p < 32; p++) begin
      phaseWord = 5'(p); cycle(7);
    end

    // R2: backward wrap through large increment
    curReq = "R2"; phaseWord = 5'd3; freqWord = 32'hFFF0_0000; cycle(600);
    freqWord = 32'h8000_0001; cycle(50);

    // R7: power-down freezes phase and parks output
    curReq = "R7"; freqWord = 32'h0031_0000; cycle(20);
    powerDown = 1'b1; cycle(10); expectAmp(512, "R7");
    curReq = "R8"; powerDown = 1'b0; cycle(5);
    curReq = "R7"; powerDown = 1'b1; cycle(1); powerDown = 1'b0;
    curReq = "R8"; cycle(30);

    // R1: reset mid-run
    curReq = "R1"; rst = 1'b1; cycle(2); rst = 1'b0;
    curReq = "R6"; freqWord = 32'h0777_0000; cycle(300);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule